// File: doc/BRIEF.md
# TDM Receive Connection Memory Output Controller

This block decides, slot by slot, what the serial side of a time-slot switch's receive path carries. A frame holds `NUM_SLOTS` destination slots, 512 by default (16 serial lines of 32 channels). A slot counter walks the frame at one slot per clock. For the current slot the block reads a connection word that the CPU wrote earlier. In switching mode, the word's 12-bit source field picks a byte from a receive data memory. That memory holds the latest byte of each of `SRC_CHANNELS` (2430) parallel-side channels. In message mode, the word's low byte is sent as it is.

The same word sets the output buffers for the slot. Each destination slot has an outbound pin (STo) and a paired inbound pin (STi). The global input `indep_mode` changes the meaning of the direction bit. With `indep_mode` low (paired), a cleared direction bit moves the output onto the STi pin of the same number. With `indep_mode` high, the direction bit sets each slot as input or output on its own. A slot is driven only when its enable bit is set and its direction makes it an output.

The parallel-side bytes enter through a valid/ready stream. `in_ready` is low during reset and in the first cycle after it, and high from then on. A byte is accepted on a clock edge where `in_valid` and `in_ready` are both high. While `in_valid` is held with `in_ready` low, the byte waits and nothing is written. The serial-side output is a TDM stream and cannot be held back. `out_valid` marks every cycle that carries a slot result.

Top module: `tdm_cm_out_ctrl`

## Requirements
- R1: While `rst` is high, and at the first edge after it, every connection word is cleared. From then on no slot drives either pin until the CPU writes a word. During reset `out_valid`, `out_slot`, `out_data`, `out_sto_oe` and `out_sti_oe` read 0.
- R2: After reset the slot counter starts at 0, steps by one each clock and wraps from `NUM_SLOTS-1` to 0. The result for slot s appears one clock after the counter holds s, with `out_valid` high and `out_slot` = s.
- R3: If the message bit is 1, `out_data` equals the word's low byte.
- R4: If the message bit is 0 and the source address {src_hi, low byte} is below `SRC_CHANNELS`, `out_data` is the data-memory byte at that address.
- R5: If the message bit is 0 and the source address is `SRC_CHANNELS` or above, `out_data` is `IDLE_BYTE` (8'hFF).
- R6: With `indep_mode` low, enable 1 and direction 1: `out_sto_oe`=1 and `out_sti_oe`=0.
- R7: With `indep_mode` low, enable 1 and direction 0: `out_sto_oe`=0 and `out_sti_oe`=1. The two enables are never both 1.
- R8: With `indep_mode` high: `out_sto_oe` = enable AND direction, and `out_sti_oe` is 0.
- R9: With enable 0, neither pin is driven, in either mode.
- R10: The CPU word layout is `cpu_hi_data`[6] message, [5] direction, [4] enable, [3:0] src_hi, and `cpu_lo_data` is the low byte. `cpu_wr_hi` and `cpu_wr_lo` write their halves independently; the other half keeps its value. A request sampled at edge k is stored at edge k+1. A slot read after that edge sees the new value.
- R11: A stream byte accepted at an edge (`in_valid` and `in_ready` both high) is stored at `in_addr`. A slot read after that edge sees it. An `in_addr` of `SRC_CHANNELS` or above is ignored. `in_ready` follows the rule stated above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| indep_mode | input | 1 | 0 = paired pin direction, 1 = independent per-slot direction |
| cpu_wr_hi | input | 1 | Write the high half of the connection word |
| cpu_wr_lo | input | 1 | Write the low half of the connection word |
| cpu_addr | input | 9 | Destination slot to write |
| cpu_hi_data | input | 7 | {message, direction, enable, src_hi[3:0]} |
| cpu_lo_data | input | 8 | Low source byte or message byte |
| in_valid | input | 1 | Parallel-side byte offered |
| in_ready | output | 1 | Data memory accepts a byte |
| in_addr | input | 12 | Parallel-side channel of the offered byte |
| in_data | input | 8 | Offered byte |
| out_valid | output | 1 | Slot result present |
| out_slot | output | 9 | Slot number of this result |
| out_data | output | 8 | Byte for this slot |
| out_sto_oe | output | 1 | Drive the outbound pin in this slot |
| out_sti_oe | output | 1 | Drive the paired inbound pin in this slot |

## Verification
A stale or corrupted connection word shows up as a wrong byte or wrong pin enables. This happens when the counter next reaches that slot, so at most one frame (512 clocks) after the fault. A counter fault breaks the `out_slot` sequence within one clock. A write that lands a cycle early or late shows only when the counter passes the written slot right at that moment. For this reason the bench writes slots while the frame is running, and it compares every port on every clock.

// File: rtl/tdm_cmoc_pkg.sv
`timescale 1ns/1ps
package tdm_cmoc_pkg;
  localparam int SRC_HI_W = 4;
  localparam int SRC_LO_W = 8;
  localparam int SRC_W    = SRC_HI_W + SRC_LO_W;
  localparam int DATA_W   = 8;
  localparam int HI_W     = 3 + SRC_HI_W;

  typedef struct packed {
    logic                msg;
    logic                dir;
    logic                oe;
    logic [SRC_HI_W-1:0] src_hi;
  } cm_hi_t;

  typedef logic [SRC_LO_W-1:0] cm_lo_t;
endpackage

// File: rtl/tdm_cmoc_cmem.sv
`timescale 1ns/1ps
module tdm_cmoc_cmem
  import tdm_cmoc_pkg::*;
#(
  parameter int NUM_SLOTS = 512,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic [SLOT_W-1:0] wr_addr,
  input  cm_hi_t            wr_hi_data,
  input  cm_lo_t            wr_lo_data,
  input  logic [SLOT_W-1:0] rd_addr,
  output cm_hi_t            rd_hi,
  output cm_lo_t            rd_lo
);
  cm_hi_t            hi_mem [NUM_SLOTS];
  cm_lo_t            lo_mem [NUM_SLOTS];
  logic              pend_hi, pend_lo;
  logic [SLOT_W-1:0] pend_addr;
  cm_hi_t            pend_hd;
  cm_lo_t            pend_ld;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        hi_mem[i] <= '0;
        lo_mem[i] <= '0;
      end
      pend_hi   <= 1'b0;
      pend_lo   <= 1'b0;
      pend_addr <= '0;
      pend_hd   <= '0;
      pend_ld   <= '0;
    end else begin
      if (pend_hi) hi_mem[pend_addr] <= pend_hd;
      if (pend_lo) lo_mem[pend_addr] <= pend_ld;
      pend_hi   <= wr_hi;
      pend_lo   <= wr_lo;
      pend_addr <= wr_addr;
      pend_hd   <= wr_hi_data;
      pend_ld   <= wr_lo_data;
    end
  end

  assign rd_hi = hi_mem[rd_addr];
  assign rd_lo = lo_mem[rd_addr];

  // R10: a registered low-half request reaches the memory at the next edge
  p_lo_lands_r10: assert property (@(posedge clk) disable iff (rst)
    pend_lo |=> lo_mem[$past(pend_addr)] == $past(pend_ld));
endmodule

// File: rtl/tdm_cmoc_dmem.sv
`timescale 1ns/1ps
module tdm_cmoc_dmem
  import tdm_cmoc_pkg::*;
#(
  parameter int DEPTH = 2430,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [SRC_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [SRC_W-1:0]  rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_in_range
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic              wr_in_range;

  assign wr_in_range = int'(wr_addr) < DEPTH;
  assign rd_in_range = int'(rd_addr) < DEPTH;

  always_ff @(posedge clk) begin
    if (wr_en && wr_in_range) mem[wr_addr[AW-1:0]] <= wr_data;
  end

  assign rd_data = rd_in_range ? mem[rd_addr[AW-1:0]] : '0;
endmodule

// File: rtl/tdm_cmoc_slot_out.sv
`timescale 1ns/1ps
module tdm_cmoc_slot_out
  import tdm_cmoc_pkg::*;
#(
  parameter int                NUM_SLOTS = 512,
  parameter logic [DATA_W-1:0] IDLE_BYTE = 8'hFF,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SLOT_W-1:0] slot,
  input  cm_hi_t            hi,
  input  cm_lo_t            lo,
  input  logic [DATA_W-1:0] dm_data,
  input  logic              dm_in_range,
  input  logic              indep_mode,
  output logic              out_valid,
  output logic [SLOT_W-1:0] out_slot,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sto_oe,
  output logic              out_sti_oe
);
  logic [DATA_W-1:0] data_n;
  logic              sto_n, sti_n;

  always_comb begin
    if (hi.msg)           data_n = lo;
    else if (dm_in_range) data_n = dm_data;
    else                  data_n = IDLE_BYTE;
    sto_n = hi.oe &  hi.dir;
    sti_n = hi.oe & ~hi.dir & ~indep_mode;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_slot   <= '0;
      out_data   <= '0;
      out_sto_oe <= 1'b0;
      out_sti_oe <= 1'b0;
    end else begin
      out_valid  <= 1'b1;
      out_slot   <= slot;
      out_data   <= data_n;
      out_sto_oe <= sto_n;
      out_sti_oe <= sti_n;
    end
  end

  p_msg_byte_r3: assert property (@(posedge clk) disable iff (rst)
    hi.msg |=> out_data == $past(lo));
  p_idle_byte_r5: assert property (@(posedge clk) disable iff (rst)
    (!hi.msg && !dm_in_range) |=> out_data == IDLE_BYTE);
  p_pins_exclusive_r7: assert property (@(posedge clk) disable iff (rst)
    !(out_sto_oe && out_sti_oe));
  p_indep_no_sti_r8: assert property (@(posedge clk) disable iff (rst)
    indep_mode |=> !out_sti_oe);
  p_disabled_r9: assert property (@(posedge clk) disable iff (rst)
    !hi.oe |=> (!out_sto_oe && !out_sti_oe));
endmodule

// File: rtl/tdm_cm_out_ctrl.sv
`timescale 1ns/1ps
module tdm_cm_out_ctrl
  import tdm_cmoc_pkg::*;
#(
  parameter int                NUM_SLOTS    = 512,
  parameter int                SRC_CHANNELS = 2430,
  parameter logic [DATA_W-1:0] IDLE_BYTE    = 8'hFF,
  localparam int SLOT_W = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              indep_mode,
  input  logic              cpu_wr_hi,
  input  logic              cpu_wr_lo,
  input  logic [SLOT_W-1:0] cpu_addr,
  input  logic [HI_W-1:0]   cpu_hi_data,
  input  logic [SRC_LO_W-1:0] cpu_lo_data,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SRC_W-1:0]  in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [SLOT_W-1:0] out_slot,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sto_oe,
  output logic              out_sti_oe
);
  logic [SLOT_W-1:0] slot_q;
  logic              ready_q;
  cm_hi_t            rd_hi;
  cm_lo_t            rd_lo;
  logic [DATA_W-1:0] dm_data;
  logic              dm_in_range;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      slot_q  <= (slot_q == SLOT_W'(NUM_SLOTS - 1)) ? '0 : slot_q + 1'b1;
      ready_q <= 1'b1;
    end
  end
  assign in_ready = ready_q;

  tdm_cmoc_cmem #(.NUM_SLOTS(NUM_SLOTS)) cmem_i (
    .clk(clk), .rst(rst),
    .wr_hi(cpu_wr_hi), .wr_lo(cpu_wr_lo), .wr_addr(cpu_addr),
    .wr_hi_data(cm_hi_t'(cpu_hi_data)), .wr_lo_data(cpu_lo_data),
    .rd_addr(slot_q), .rd_hi(rd_hi), .rd_lo(rd_lo)
  );

  tdm_cmoc_dmem #(.DEPTH(SRC_CHANNELS)) dmem_i (
    .clk(clk), .wr_en(in_valid && ready_q), .wr_addr(in_addr),
    .wr_data(in_data), .rd_addr({rd_hi.src_hi, rd_lo}),
    .rd_data(dm_data), .rd_in_range(dm_in_range)
  );

  tdm_cmoc_slot_out #(.NUM_SLOTS(NUM_SLOTS), .IDLE_BYTE(IDLE_BYTE)) sout_i (
    .clk(clk), .rst(rst), .slot(slot_q), .hi(rd_hi), .lo(rd_lo),
    .dm_data(dm_data), .dm_in_range(dm_in_range), .indep_mode(indep_mode),
    .out_valid(out_valid), .out_slot(out_slot), .out_data(out_data),
    .out_sto_oe(out_sto_oe), .out_sti_oe(out_sti_oe)
  );

  p_slot_step_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(out_valid)) |->
      out_slot == (($past(out_slot) == SLOT_W'(NUM_SLOTS - 1)) ? '0 : $past(out_slot) + 1'b1));
  p_ready_after_reset_r11: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> in_ready);
endmodule

// File: tb/tdm_cm_out_ctrl_tb_top.sv
`timescale 1ns/1ps
module tdm_cm_out_ctrl_tb_top;
  localparam int NS   = 512;
  localparam int NSRC = 2430;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, indep_mode = 1'b0;
  logic cpu_wr_hi = 1'b0, cpu_wr_lo = 1'b0;
  logic [8:0] cpu_addr = '0;
  logic [6:0] cpu_hi_data = '0;
  logic [7:0] cpu_lo_data = '0;
  logic in_valid = 1'b0, in_ready;
  logic [11:0] in_addr = '0;
  logic [7:0] in_data = '0;
  logic out_valid, out_sto_oe, out_sti_oe;
  logic [8:0] out_slot;
  logic [7:0] out_data;

  tdm_cm_out_ctrl dut_i (
    .clk(clk), .rst(rst), .indep_mode(indep_mode),
    .cpu_wr_hi(cpu_wr_hi), .cpu_wr_lo(cpu_wr_lo), .cpu_addr(cpu_addr),
    .cpu_hi_data(cpu_hi_data), .cpu_lo_data(cpu_lo_data),
    .in_valid(in_valid), .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .out_valid(out_valid), .out_slot(out_slot), .out_data(out_data),
    .out_sto_oe(out_sto_oe), .out_sti_oe(out_sti_oe)
  );

  // Behavioural reference state
  int  m_hi[NS], m_lo[NS], m_wtime[NS], m_dm[NSRC];
  bit  m_known[NSRC];
  int  m_slot, cyc, compared, mismatched;
  bit  m_ready, p_hi, p_lo, done, e_valid, e_dknown, e_ready;
  int  p_addr, p_hd, p_ld, e_slot, e_data, e_sto, e_sti;
  string e_dtag, e_ptag;

  initial begin
    for (int i = 0; i < NS; i++) m_wtime[i] = -100;
    for (int i = 0; i < NSRC; i++) m_known[i] = 1'b0;
  end

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      for (int i = 0; i < NS; i++) begin m_hi[i] = 0; m_lo[i] = 0; end
      m_slot = 0; m_ready = 0; p_hi = 0; p_lo = 0;
      e_valid = 0; e_slot = 0; e_data = 0; e_sto = 0; e_sti = 0;
      e_dknown = 1; e_dtag = "R1"; e_ptag = "R1";
    end else begin
      int hi, src;
      bit msg, dir, oe, recent;
      hi  = m_hi[m_slot];
      msg = hi[6]; dir = hi[5]; oe = hi[4];
      src = (hi & 15) * 256 + m_lo[m_slot];
      recent = (cyc - m_wtime[m_slot]) <= 2;
      if (msg) begin e_data = m_lo[m_slot]; e_dknown = 1; e_dtag = "R3"; end
      else if (src >= NSRC) begin e_data = 255; e_dknown = 1; e_dtag = "R5"; end
      else begin e_data = m_dm[src]; e_dknown = m_known[src]; e_dtag = "R4"; end
      e_sto = oe && dir;
      e_sti = oe && !dir && !indep_mode;
      e_ptag = !oe ? "R9" : indep_mode ? "R8" : dir ? "R6" : "R7";
      if (recent) begin e_dtag = "R10"; e_ptag = "R10"; end
      e_valid = 1; e_slot = m_slot;
      // R11: stream accept
      if (in_valid && m_ready && in_addr < NSRC) begin
        m_dm[in_addr] = in_data; m_known[in_addr] = 1;
      end
      // R10: one-cycle write pipeline
      if (p_hi) begin m_hi[p_addr] = p_hd; m_wtime[p_addr] = cyc; end
      if (p_lo) begin m_lo[p_addr] = p_ld; m_wtime[p_addr] = cyc; end
      p_hi = cpu_wr_hi; p_lo = cpu_wr_lo; p_addr = cpu_addr;
      p_hd = cpu_hi_data; p_ld = cpu_lo_data;
      m_slot = (m_slot + 1) % NS;
      m_ready = 1;
    end
    e_ready = m_ready;
    if (cyc > 150000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: run did not finish, actual=%0d expected<=%0d", cyc, 150000);
      finish_run();
    end
  end

  task automatic check(bit ok, string tag, string what, int act, int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual=%0d expected=%0d", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc >= 1 && !done) begin
      string vt;
      vt = rst ? "R1" : "R2";
      check(out_valid == e_valid, vt, "out_valid", out_valid, e_valid);
      check(out_slot == e_slot, vt, "out_slot", out_slot, e_slot);
      check(out_sto_oe == e_sto, e_ptag, "out_sto_oe", out_sto_oe, e_sto);
      check(out_sti_oe == e_sti, e_ptag, "out_sti_oe", out_sti_oe, e_sti);
      if (e_dknown) check(out_data == e_data, e_dtag, "out_data", out_data, e_data);
      check(in_ready == e_ready, "R11", "in_ready", in_ready, e_ready);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic cfg(int slot, int hi, int lo, bit whi = 1, bit wlo = 1);
    cpu_wr_hi = whi; cpu_wr_lo = wlo; cpu_addr = slot[8:0];
    cpu_hi_data = hi[6:0]; cpu_lo_data = lo[7:0];
    tick();
    cpu_wr_hi = 0; cpu_wr_lo = 0;
  endtask

  initial begin
    tick(4);
    rst = 0;
    // R1 / R9: nothing is driven before configuration, full frame
    tick(600);
    // R11: fill the data memory with gaps in valid, plus one out-of-range byte
    for (int a = 0; a < NSRC; a++) begin
      if (a % 7 == 6) begin in_valid = 0; tick(); end
      in_valid = 1; in_addr = a[11:0]; in_data = 8'((a * 7 + 3) & 255);
      tick();
    end
    in_addr = 12'd4000; in_data = 8'h5A; tick();
    in_valid = 0;
    // R3..R9: directed slot words
    cfg(0,   8'h70, 8'h00);
    cfg(3,   8'h70, 8'hA5);
    cfg(4,   8'h30, 8'h00);
    cfg(5,   8'h39, 8'h7D);   // source 2429, direction 1
    cfg(6,   8'h19, 8'h7E);   // source 2430 -> idle byte (R5), direction 0
    cfg(7,   8'h1F, 8'hFF);   // source 4095 -> idle byte (R5)
    cfg(8,   8'h60, 8'h3C);   // message, enable 0 (R9)
    cfg(9,   8'h50, 8'h11);   // message, direction 0 (R7)
    cfg(10,  8'h19, 8'h7D);   // source 2429, direction 0
    cfg(511, 8'h34, 8'hD2);   // source 1234
    for (int i = 16; i < 48; i++)
      cfg(i, ((i % 3 == 0) ? 64 : 0) | ((i & 1) << 5) | (((i >> 1) & 1) << 4) | ((i * 50) >> 8),
          (i * 50) & 255);
    tick(1100);
    // R8: independent direction mode
    indep_mode = 1;
    tick(1100);
    // R10: half writes and writes landing while the counter runs
    cfg(3, 8'h32, 8'h00, 1, 0);
    cfg(5, 8'h00, 8'h10, 0, 1);
    for (int k = 0; k < 40; k++)
      cfg((k * 13) % NS, ((k & 3) << 4) | (k & 8 ? 64 : 0) | (k % 10), (k * 37) & 255);
    tick(600);
    indep_mode = 0;
    // R11: data changes while slots keep reading it
    for (int a = 0; a < 64; a++) begin
      in_valid = 1; in_addr = 12'(a * 38); in_data = 8'(255 - a); tick();
    end
    in_valid = 0;
    tick(1100);
    finish_run();
  end
endmodule